// File: doc/BRIEF.md
# Periodic Alignment Comma Inserter

This block sits in a transmit path just ahead of a 10-bit serializer. Upstream logic hands it code groups that are already 8B/10B encoded, one per cycle under a ready/valid handshake, and marks the last word of every cell or packet. The block forwards those words to a registered 10-bit output, one per reference-clock cycle. It also injects bursts of alignment commas that let the far-end receiver find the word boundary again.

A burst is three back-to-back K28.5 code groups. One burst goes out straight after reset, before any data. After that, a new burst follows every time a programmable number of cells has been sent, so that phase drift from temperature, supply or jitter can be recovered. A burst only ever starts on a cell boundary. While it is sent, upstream sees `in_ready` low and keeps its word, so nothing is lost. Each comma is picked to match the running disparity of the words sent so far. An interval of zero turns the periodic bursts off.

Top module: `comma_burst_inserter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 0.
- R2: After reset, the first three words with `out_valid` high are commas, and no data word comes out before them.
- R3: A comma is `10'b0011111010` when the running disparity is negative and `10'b1100000101` when it is positive, where bit 9 is the first bit serialized.
- R4: The running disparity is negative after reset. After each word sent with more than five ones it becomes positive. After each word with fewer than five ones it becomes negative. A word with exactly five ones leaves it unchanged. Commas update it by the same rule.
- R5: Every burst is exactly three consecutive comma words, and during a burst `in_ready` stays low for exactly three cycles.
- R6: With `cell_interval` = N > 0, a burst starts in the cycle after the word carrying `in_eoc` of the N-th cell since the last burst is accepted.
- R7: A burst never starts in the middle of a cell. `in_ready` only falls in the cycle after a word with `in_eoc` high is accepted.
- R8: A word accepted when `in_valid` and `in_ready` are both high appears unchanged on `out_data`, with `out_valid` high, on the next cycle. Words keep their order and none is dropped or duplicated.
- R9: With `cell_interval` = 0, no burst follows the one sent at start-up.
- R10: The cell count restarts from zero after every burst.
- R11: When `in_ready` is low, `in_valid` and `in_data` have no effect on the output. The held word comes out only after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one code group per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a code group |
| in_ready | output | 1 | Block accepts the offered code group this cycle |
| in_data | input | 10 | Encoded code group from upstream |
| in_eoc | input | 1 | Offered word is the last word of its cell or packet |
| cell_interval | input | 16 | Cells between bursts; 0 disables periodic bursts |
| out_data | output | 10 | Code group toward the serializer |
| out_valid | output | 1 | `out_data` holds a data word or a comma |

## Verification
A word accepted at a clock edge shows up on `out_data` at the next edge, which is one cycle of latency. The first comma of a burst comes out one cycle after the end-of-cell word, and the burst's three commas fill that cycle and the two after it. `in_ready` goes low in the cycle straight after that end-of-cell acceptance. The driver applies stimulus just after a rising edge and records the expected item in the same cycle it sees `in_ready` high. The monitor samples on the falling edge and pops one expected item for each valid output word. It rebuilds the running disparity from the words it actually observed, so each comma is checked against the polarity that every earlier word implies. It also measures each low stretch of `in_ready` in cycles.

// File: rtl/cib_pkg.sv
package cib_pkg;

    localparam int unsigned CODE_W = 10;

    // K28.5 in both disparity forms, bit 9 serialized first
    localparam logic [CODE_W-1:0] K285_RDN = 10'b0011111010;
    localparam logic [CODE_W-1:0] K285_RDP = 10'b1100000101;

    typedef enum logic {
        PH_BURST = 1'b0,
        PH_PASS  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [1:0]        beat;
        logic [CODE_W-1:0] word;
        logic              vld;
    } tx_state_t;

endpackage

// File: rtl/cib_disparity.sv
module cib_disparity #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] word,
    output logic         rd_pos
);
    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam int unsigned HALF  = W / 2;

    logic [CNT_W-1:0] ones;
    logic             rd_d, rd_q;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CNT_W'(word[i]);
        end
        rd_d = rd_q;
        if (upd) begin
            if (ones > CNT_W'(HALF)) begin
                rd_d = 1'b1;
            end else if (ones < CNT_W'(HALF)) begin
                rd_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_pos = rd_q;

    // R4: a balanced word leaves the disparity where it was
    p_balanced_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && $countones(word) == HALF) |=> $stable(rd_pos));

endmodule

// File: rtl/cib_cell_counter.sv
module cib_cell_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cell_done,
    input  logic [CNT_W-1:0] interval,
    output logic             due
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   next_cnt;

    always_comb begin
        next_cnt = {1'b0, cnt_q} + 1'b1;
        due      = cell_done && (interval != '0) && (next_cnt >= {1'b0, interval});
        cnt_d    = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (cell_done && !due) begin
            cnt_d = next_cnt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: a zero interval never requests a burst
    p_zero_interval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |-> !due);

endmodule

// File: rtl/comma_burst_inserter.sv
module comma_burst_inserter
    import cib_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned BURST_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_data,
    input  logic              in_eoc,
    input  logic [CNT_W-1:0]  cell_interval,
    output logic [CODE_W-1:0] out_data,
    output logic              out_valid
);
    localparam logic [1:0] LAST_BEAT = 2'(BURST_LEN - 1);

    tx_state_t st_d, st_q;
    logic      rd_pos;
    logic      cell_done;
    logic      burst_done;
    logic      due;

    cib_disparity #(.W(CODE_W)) u_disp (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (st_d.vld),
        .word   (st_d.word),
        .rd_pos (rd_pos)
    );

    cib_cell_counter #(.CNT_W(CNT_W)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (burst_done),
        .cell_done (cell_done),
        .interval  (cell_interval),
        .due       (due)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.word  = '0;
        in_ready   = 1'b0;
        cell_done  = 1'b0;
        burst_done = 1'b0;
        case (st_q.phase)
            PH_BURST: begin
                st_d.vld  = 1'b1;
                st_d.word = rd_pos ? K285_RDP : K285_RDN;
                if (st_q.beat == LAST_BEAT) begin
                    st_d.phase = PH_PASS;
                    st_d.beat  = '0;
                    burst_done = 1'b1;
                end else begin
                    st_d.beat = st_q.beat + 2'd1;
                end
            end
            default: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    st_d.vld  = 1'b1;
                    st_d.word = in_data;
                    cell_done = in_eoc;
                    if (due) begin
                        st_d.phase = PH_BURST;
                        st_d.beat  = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_BURST, beat: '0, word: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.word;
    assign out_valid = st_q.vld;

    // Run length of in_ready low, kept for the burst-length check only
    logic [2:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (in_ready) begin
            low_run_q <= '0;
        end else if (low_run_q != 3'd7) begin
            low_run_q <= low_run_q + 3'd1;
        end
    end

    // R8: an accepted word is forwarded unchanged one cycle later
    p_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R3: every cycle with in_ready low sends a K28.5 in one of its two forms
    p_comma_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (out_valid && (out_data == K285_RDN || out_data == K285_RDP)));

    // R5: in_ready is held low for exactly the burst length
    p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (low_run_q == 3'(BURST_LEN)));

    // R7: in_ready only falls after an end-of-cell word was taken
    p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid && in_eoc));

    // R1: no output in the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !in_ready));

endmodule

// File: tb/comma_burst_inserter_tb_top.sv
module comma_burst_inserter_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [9:0] KN = 10'b0011111010;
    localparam logic [9:0] KP = 10'b1100000101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_data = '0;
    logic        in_eoc = 1'b0;
    logic [15:0] cell_interval = 16'd2;
    logic [9:0]  out_data;
    logic        out_valid;

    int checks = 0;
    int errors = 0;

    // Expected items: bit 10 marks a comma token, else bits 9:0 are data
    logic [10:0] exp_q[$];
    bit          rd_pos_m = 1'b0;
    int          low_run = 0;
    int          bench_cells = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    comma_burst_inserter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .in_eoc        (in_eoc),
        .cell_interval (cell_interval),
        .out_data      (out_data),
        .out_valid     (out_valid)
    );

    task automatic check(bit ok, string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_burst();
        for (int i = 0; i < 3; i++) exp_q.push_back(11'h400);
    endtask

    // Offer one word, hold it until taken (R11), then predict the output
    task automatic send_word(logic [9:0] d, bit eoc);
        in_valid = 1'b1;
        in_data  = d;
        in_eoc   = eoc;
        while (!in_ready) begin
            @(posedge clk); #2;
        end
        exp_q.push_back({1'b0, d});
        if (eoc) begin
            bench_cells++;
            if (cell_interval != 0 && bench_cells == int'(cell_interval)) begin
                push_burst();
                bench_cells = 0; // R10
            end
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
        in_eoc   = 1'b0;
    endtask

    task automatic send_cell(int len, logic [9:0] base);
        for (int i = 0; i < len; i++) send_word(base + 10'(i * 37), i == len - 1);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic do_reset(logic [15:0] ival);
        rst_n = 1'b0;
        cell_interval = ival;
        in_valid = 1'b1;       // ignored during reset
        in_data  = 10'h155;
        idle(3);
        check(out_valid == 1'b0, "R1 out_valid in reset", {9'd0, out_valid}, 10'd0);
        check(in_ready == 1'b0, "R1 in_ready in reset", {9'd0, in_ready}, 10'd0);
        in_valid = 1'b0;
        exp_q.delete();
        rd_pos_m = 1'b0;
        bench_cells = 0;
        low_run = 0;
        push_burst(); // R2 start-up burst
        rst_n = 1'b1;
    endtask

    // Monitor: scoreboard compare and in_ready run length
    always @(negedge clk) begin
        if (rst_n) begin
            if (!in_ready) begin
                low_run++;
            end else if (low_run > 0) begin
                check(low_run == 3, "R5 ready-low length", 10'(low_run), 10'd3);
                low_run = 0;
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected output word", out_data, 10'h000);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    if (e[10]) begin
                        check(out_data == (rd_pos_m ? KP : KN), "R3/R4 comma polarity",
                              out_data, rd_pos_m ? KP : KN);
                    end else begin
                        check(out_data == e[9:0], "R8 data word", out_data, e[9:0]);
                    end
                end
                if ($countones(out_data) > 5) rd_pos_m = 1'b1;
                else if ($countones(out_data) < 5) rd_pos_m = 1'b0;
            end
        end
    end

    initial begin
        // Phase A: interval 2, mixed lengths and disparities (R2, R4, R6, R7, R10)
        do_reset(16'd2);
        send_word(10'h155, 1'b0); // offered while in_ready low: R11
        send_word(10'h3F0, 1'b1); // six ones: disparity goes positive
        send_cell(3, 10'h02B);
        send_word(10'h00F, 1'b1); // four ones
        send_cell(2, 10'h0F3);
        idle(2);
        send_cell(4, 10'h111);
        send_word(10'h01F, 1'b1); // balanced
        send_word(10'h3F0, 1'b1);
        send_word(10'h2AA, 1'b1);
        idle(6);
        check(exp_q.size() == 0, "R8 all words delivered A", 10'(exp_q.size()), 10'd0);

        // Phase B: interval 0 disables periodic bursts (R9)
        do_reset(16'd0);
        for (int c = 0; c < 5; c++) send_cell(c + 1, 10'(c * 51 + 7));
        idle(6);
        check(exp_q.size() == 0, "R9 no extra bursts", 10'(exp_q.size()), 10'd0);

        // Phase C: interval 1, a burst after every single-word cell (R6)
        do_reset(16'd1);
        send_word(10'h3F0, 1'b1);
        send_word(10'h3F0, 1'b1);
        send_word(10'h00F, 1'b1);
        send_cell(2, 10'h0A5);
        idle(6);
        check(exp_q.size() == 0, "R6 all words delivered C", 10'(exp_q.size()), 10'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule